// File: doc/BRIEF.md
# Single-Line Burst Read Buffer

This block sits in the read path between a requester and a system bus. It holds one 16-byte line, its 28-bit line tag and a valid flag. A read whose address lies in the cacheable segment and whose bytes fit inside one 16-byte line is checked against the held line. On a hit, the bytes come straight from the line and nothing appears on the system bus. On a miss, the block fetches the whole aligned line as a two-beat 64-bit burst and stores it. It answers only after both beats have arrived.

Reads outside the cacheable segment, and cacheable reads whose bytes would run past the end of a line, go to the bus as single accesses of the requested size. Their data is returned without being stored, and the buffer keeps its contents. The block handles one request at a time. It takes a new request only in its idle state and answers each request with exactly one response.

The controller has eight states.
- IDLE accepts a request and routes it three ways: a hit goes to LINE_RSP, a cacheable miss goes to FILL_CMD, and anything else goes to SINGLE_CMD.
- FILL_CMD issues the burst and moves to FILL_WAIT once the bus accepts the command.
- FILL_WAIT collects the beats. After the last good beat it moves to LINE_RSP. An erroneous beat sends it to ERR_RSP.
- SINGLE_CMD issues the single access and moves to SINGLE_WAIT once the bus accepts it.
- SINGLE_WAIT moves to SINGLE_RSP on a good beat and to ERR_RSP on an erroneous beat.
- LINE_RSP, SINGLE_RSP and ERR_RSP each present one response and return to IDLE.

Top module: `line_read_buffer`

## Requirements
- R1: After reset the line is invalid, so the first cacheable read always goes to the bus. While in reset and just after it, `req_ready` is 1 and `rsp_valid` and `bus_cmd_valid` are 0.
- R2: An address is cacheable exactly when its bits 31:28 equal 4'h8, which covers 0x8000_0000 to 0x8FFF_FFFF. Any other read is issued with `bus_cmd_burst`=0, the exact request address, and `bus_cmd_size` equal to `req_size`.
- R3: A cacheable miss issues one command with `bus_cmd_burst`=1, `bus_cmd_size`=3, and the request address with bits 3:0 cleared.
- R4: The size codes are 0, 1, 2 and 3, meaning 1, 2, 4 and 8 bytes. Little-endian byte order applies. The first burst beat holds line bytes 0 to 7 and the second holds bytes 8 to 15. `rsp_data` byte i equals memory byte (address + i) for each requested byte, and the remaining upper bits are 0.
- R5: A hit requires three things: a valid line, a tag equal to address bits 31:4, and all requested bytes inside that line. A hit issues no bus command and responds in the cycle after acceptance.
- R6: A miss responds in the cycle after the second beat. A single access responds in the cycle after its only beat. With a slave that answers one cycle after the command, a hit therefore takes 1 cycle, an uncached read 3 cycles, and a miss 4 cycles.
- R7: A read outside the window leaves the line and its tag unchanged. A later read of the held line still hits.
- R8: A cacheable read where (address bits 3:0) + size in bytes exceeds 16 is issued as a single access and leaves the buffer unchanged.
- R9: If a fill beat returns with `bus_rerr`=1, the block responds with `rsp_err`=1 and `rsp_data`=0 and leaves the line invalid. A repeat of the same read issues a new burst.
- R10: An error on a single access gives `rsp_err`=1 and leaves the buffer unchanged.
- R11: Only one request is in flight at a time. `req_ready` is 0 from acceptance through the response cycle and returns to 1 in the cycle after the response.
- R12: A miss to a different line replaces the held line. A read of the earlier line then misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_addr | input | 32 | Byte address of the read |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Requested bytes, right-aligned, zero above |
| rsp_err | output | 1 | Response carries a bus error |
| bus_cmd_valid | output | 1 | Bus command present |
| bus_cmd_ready | input | 1 | Bus accepts the command |
| bus_cmd_addr | output | 32 | Bus command address |
| bus_cmd_burst | output | 1 | 1 = two-beat line burst, 0 = single access |
| bus_cmd_size | output | 2 | Access size code |
| bus_rvalid | input | 1 | Read beat present |
| bus_rdata | input | 64 | Beat data (single access: right-aligned) |
| bus_rerr | input | 1 | Beat carries an error; ends the transfer |

## Verification
Reads are issued in several patterns:
- A first read to an empty buffer, then reads to both halves of the held line. These separate the lower and upper beat placement and the hit and miss timing.
- Uncached reads that share low address bits with the held line, and reads at both edges of the window. These show whether segment decoding and buffer isolation are right.
- A read that spills past the end of the line and a read to a second line. These show the boundary rule and line replacement.
- An error injected on the second fill beat and on a single beat. These distinguish the fill error, which must leave the line invalid, from the single-access error, which must leave it intact.

Latency, the number of bus commands, and their address, burst flag and size are compared on every read.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_CMD,
        ST_FILL_WAIT,
        ST_LINE_RSP,
        ST_SINGLE_CMD,
        ST_SINGLE_WAIT,
        ST_SINGLE_RSP,
        ST_ERR_RSP
    } lrb_state_e;

    localparam logic [1:0] SZ_DWORD = 2'd3;

    function automatic int unsigned size_bytes(input logic [1:0] code);
        unique case (code)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/lrb_lookup.sv
module lrb_lookup #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned OFF_W      = 4,
    parameter int unsigned SEG_W      = 4,
    parameter logic [3:0]  WIN_SEG    = 4'h8,
    parameter int unsigned LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [1:0]              size_i,
    input  logic                    line_valid_i,
    input  logic [ADDR_W-OFF_W-1:0] line_tag_i,
    output logic                    in_window_o,
    output logic                    spills_o,
    output logic                    hit_o
);
    import lrb_pkg::*;

    logic [OFF_W+1:0] end_off;

    always_comb begin
        in_window_o = (addr_i[ADDR_W-1 -: SEG_W] == WIN_SEG[SEG_W-1:0]);
        end_off     = {2'b00, addr_i[OFF_W-1:0]} + (OFF_W+2)'(size_bytes(size_i));
        spills_o    = (end_off > (OFF_W+2)'(LINE_BYTES));
        hit_o       = in_window_o && !spills_o && line_valid_i
                      && (line_tag_i == addr_i[ADDR_W-1:OFF_W]);
    end

endmodule

// File: rtl/lrb_line_store.sv
module lrb_line_store #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned BEAT_W = 64,
    parameter int unsigned BEATS  = 2,
    parameter int unsigned BC_W   = 1,
    localparam int unsigned LINE_W = BEAT_W * BEATS,
    localparam int unsigned TAG_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_start_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic              beat_we_i,
    input  logic [BC_W-1:0]   beat_idx_i,
    input  logic [BEAT_W-1:0] beat_data_i,
    input  logic              fill_done_i,
    input  logic              fill_abort_i,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [LINE_W-1:0] line_o
);
    logic [BEAT_W-1:0] seg_q [BEATS];
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;

    for (genvar b = 0; b < BEATS; b++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[b] <= '0;
            end else if (beat_we_i && (beat_idx_i == BC_W'(b))) begin
                seg_q[b] <= beat_data_i;
            end
        end
        assign line_o[b*BEAT_W +: BEAT_W] = seg_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else begin
            if (fill_start_i) begin
                valid_q <= 1'b0;
                tag_q   <= fill_tag_i;
            end else if (fill_abort_i) begin
                valid_q <= 1'b0;
            end else if (fill_done_i) begin
                valid_q <= 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign tag_o   = tag_q;

    // R7
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_we_i |=> $stable(line_o));

    // R12
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_start_i |=> $stable(tag_q));

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_abort_i |=> !valid_q);

endmodule

// File: rtl/lrb_ctrl.sv
module lrb_ctrl #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned SEG_W  = 4,
    parameter logic [3:0]  WIN_SEG = 4'h8,
    parameter int unsigned BEAT_W = 64,
    parameter int unsigned BEATS  = 2,
    parameter int unsigned BC_W   = 1,
    localparam int unsigned LINE_W = BEAT_W * BEATS,
    localparam int unsigned TAG_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic              in_window_i,
    input  logic              spills_i,
    input  logic              hit_i,
    input  logic              line_valid_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              rsp_valid_o,
    output logic [BEAT_W-1:0] rsp_data_o,
    output logic              rsp_err_o,
    output logic              bus_cmd_valid_o,
    input  logic              bus_cmd_ready_i,
    output logic [ADDR_W-1:0] bus_cmd_addr_o,
    output logic              bus_cmd_burst_o,
    output logic [1:0]        bus_cmd_size_o,
    input  logic              bus_rvalid_i,
    input  logic [BEAT_W-1:0] bus_rdata_i,
    input  logic              bus_rerr_i,
    output logic              fill_start_o,
    output logic [TAG_W-1:0]  fill_tag_o,
    output logic              beat_we_o,
    output logic [BC_W-1:0]   beat_idx_o,
    output logic              fill_done_o,
    output logic              fill_abort_o
);
    import lrb_pkg::*;

    lrb_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [BC_W-1:0]   beat_q;
    logic [BEAT_W-1:0] sdata_q;

    logic              accept;
    logic              last_beat;
    logic [LINE_W-1:0] line_shift;
    logic [BEAT_W-1:0] size_mask;

    assign accept    = (state_q == ST_IDLE) && req_valid_i;
    assign last_beat = (beat_q == BC_W'(BEATS - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (hit_i)                          state_d = ST_LINE_RSP;
                    else if (in_window_i && !spills_i)  state_d = ST_FILL_CMD;
                    else                                state_d = ST_SINGLE_CMD;
                end
            end
            ST_FILL_CMD:    if (bus_cmd_ready_i) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: begin
                if (bus_rvalid_i) begin
                    if (bus_rerr_i)     state_d = ST_ERR_RSP;
                    else if (last_beat) state_d = ST_LINE_RSP;
                end
            end
            ST_SINGLE_CMD:  if (bus_cmd_ready_i) state_d = ST_SINGLE_WAIT;
            ST_SINGLE_WAIT: begin
                if (bus_rvalid_i) state_d = bus_rerr_i ? ST_ERR_RSP : ST_SINGLE_RSP;
            end
            ST_LINE_RSP,
            ST_SINGLE_RSP,
            ST_ERR_RSP:     state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // state register and request/data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            size_q  <= '0;
            beat_q  <= '0;
            sdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= req_addr_i;
                size_q <= req_size_i;
                beat_q <= '0;
            end
            if (beat_we_o) begin
                beat_q <= beat_q + BC_W'(1);
            end
            if ((state_q == ST_SINGLE_WAIT) && bus_rvalid_i) begin
                sdata_q <= bus_rdata_i;
            end
        end
    end

    // outputs
    always_comb begin
        line_shift = line_i >> {addr_q[OFF_W-1:0], 3'b000};
        size_mask  = {BEAT_W{1'b1}} >> (BEAT_W - 8 * size_bytes(size_q));

        req_ready_o     = 1'b0;
        rsp_valid_o     = 1'b0;
        rsp_err_o       = 1'b0;
        rsp_data_o      = '0;
        bus_cmd_valid_o = 1'b0;
        bus_cmd_burst_o = 1'b0;
        bus_cmd_addr_o  = addr_q;
        bus_cmd_size_o  = size_q;
        beat_we_o       = 1'b0;
        fill_done_o     = 1'b0;
        fill_abort_o    = 1'b0;

        unique case (state_q)
            ST_IDLE:        req_ready_o = 1'b1;
            ST_FILL_CMD: begin
                bus_cmd_valid_o = 1'b1;
                bus_cmd_burst_o = 1'b1;
                bus_cmd_addr_o  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                bus_cmd_size_o  = SZ_DWORD;
            end
            ST_FILL_WAIT: begin
                beat_we_o    = bus_rvalid_i && !bus_rerr_i;
                fill_done_o  = bus_rvalid_i && !bus_rerr_i && last_beat;
                fill_abort_o = bus_rvalid_i && bus_rerr_i;
            end
            ST_SINGLE_CMD:  bus_cmd_valid_o = 1'b1;
            ST_SINGLE_WAIT: ;
            ST_LINE_RSP: begin
                rsp_valid_o = 1'b1;
                rsp_data_o  = line_shift[BEAT_W-1:0] & size_mask;
            end
            ST_SINGLE_RSP: begin
                rsp_valid_o = 1'b1;
                rsp_data_o  = sdata_q & size_mask;
            end
            ST_ERR_RSP: begin
                rsp_valid_o = 1'b1;
                rsp_err_o   = 1'b1;
            end
            default: ;
        endcase
    end

    assign fill_start_o = accept && !hit_i && in_window_i && !spills_i;
    assign fill_tag_o   = req_addr_i[ADDR_W-1:OFF_W];
    assign beat_idx_o   = beat_q;

    // R5
    line_rsp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINE_RSP) |-> line_valid_i);

    // R3
    burst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid_o && bus_cmd_burst_o) |-> (bus_cmd_addr_o[ADDR_W-1 -: SEG_W] == WIN_SEG[SEG_W-1:0]));

    // R6
    line_rsp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINE_RSP) |-> ($past(state_q) == ST_IDLE || $past(fill_done_o)));

    // R11
    idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> req_ready_o);

endmodule

// File: rtl/line_read_buffer.sv
module line_read_buffer #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SEG_W   = 4,
    parameter logic [3:0]  WIN_SEG = 4'h8,
    parameter int unsigned BEAT_W  = 64,
    parameter int unsigned BEATS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    output logic [BEAT_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              bus_cmd_valid,
    input  logic              bus_cmd_ready,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic              bus_cmd_burst,
    output logic [1:0]        bus_cmd_size,
    input  logic              bus_rvalid,
    input  logic [BEAT_W-1:0] bus_rdata,
    input  logic              bus_rerr
);
    localparam int unsigned LINE_BYTES = (BEAT_W / 8) * BEATS;
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
    localparam int unsigned LINE_W     = BEAT_W * BEATS;
    localparam int unsigned TAG_W      = ADDR_W - OFF_W;
    localparam int unsigned BC_W       = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic              in_window, spills, hit;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [LINE_W-1:0] line_data;
    logic              fill_start, beat_we, fill_done, fill_abort;
    logic [TAG_W-1:0]  fill_tag;
    logic [BC_W-1:0]   beat_idx;

    lrb_lookup #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEG_W(SEG_W),
        .WIN_SEG(WIN_SEG), .LINE_BYTES(LINE_BYTES)
    ) u_lookup (
        .addr_i(req_addr), .size_i(req_size),
        .line_valid_i(line_valid), .line_tag_i(line_tag),
        .in_window_o(in_window), .spills_o(spills), .hit_o(hit)
    );

    lrb_line_store #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BEAT_W(BEAT_W),
        .BEATS(BEATS), .BC_W(BC_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .fill_start_i(fill_start), .fill_tag_i(fill_tag),
        .beat_we_i(beat_we), .beat_idx_i(beat_idx), .beat_data_i(bus_rdata),
        .fill_done_i(fill_done), .fill_abort_i(fill_abort),
        .valid_o(line_valid), .tag_o(line_tag), .line_o(line_data)
    );

    lrb_ctrl #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEG_W(SEG_W), .WIN_SEG(WIN_SEG),
        .BEAT_W(BEAT_W), .BEATS(BEATS), .BC_W(BC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_size_i(req_size),
        .in_window_i(in_window), .spills_i(spills), .hit_i(hit),
        .line_valid_i(line_valid), .line_i(line_data),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_err_o(rsp_err),
        .bus_cmd_valid_o(bus_cmd_valid), .bus_cmd_ready_i(bus_cmd_ready),
        .bus_cmd_addr_o(bus_cmd_addr), .bus_cmd_burst_o(bus_cmd_burst),
        .bus_cmd_size_o(bus_cmd_size),
        .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata), .bus_rerr_i(bus_rerr),
        .fill_start_o(fill_start), .fill_tag_o(fill_tag),
        .beat_we_o(beat_we), .beat_idx_o(beat_idx),
        .fill_done_o(fill_done), .fill_abort_o(fill_abort)
    );

    // R5
    hit_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=> !bus_cmd_valid);

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/line_read_buffer_tb.sv
module line_read_buffer_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_err;
    logic        bus_cmd_valid;
    logic        bus_cmd_ready = 1'b1;
    logic [31:0] bus_cmd_addr;
    logic        bus_cmd_burst;
    logic [1:0]  bus_cmd_size;
    logic        bus_rvalid = 1'b0;
    logic [63:0] bus_rdata = '0;
    logic        bus_rerr = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    // slave model state
    int          cmd_cnt  = 0;
    logic [31:0] last_addr = '0;
    logic        last_burst = 1'b0;
    logic [1:0]  last_size = '0;
    int          slv_left = 0;
    int          slv_beat = 0;
    logic [31:0] slv_addr = '0;
    logic        slv_burst = 1'b0;
    logic [1:0]  slv_size = '0;
    int          inj_beat = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_read_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd_ready(bus_cmd_ready),
        .bus_cmd_addr(bus_cmd_addr), .bus_cmd_burst(bus_cmd_burst),
        .bus_cmd_size(bus_cmd_size),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
    endfunction

    function automatic logic [63:0] mem_bytes(input logic [31:0] a, input logic [1:0] sz);
        logic [63:0] d = '0;
        int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 8;
        for (int i = 0; i < nb; i++) d[8*i +: 8] = mem_byte(a + 32'(i));
        return d;
    endfunction

    // bus slave: answers one cycle after the command is accepted
    always @(negedge clk) begin
        bus_rvalid = 1'b0;
        bus_rerr   = 1'b0;
        bus_rdata  = '0;
        if (slv_left > 0) begin
            bus_rvalid = 1'b1;
            if (inj_beat == slv_beat) begin
                bus_rerr = 1'b1;
                slv_left = 0;
            end else begin
                if (slv_burst) bus_rdata = mem_bytes(slv_addr + 32'(8 * slv_beat), 2'd3);
                else           bus_rdata = mem_bytes(slv_addr, slv_size);
                slv_left--;
                slv_beat++;
            end
        end
        if (bus_cmd_valid && rst_n) begin
            cmd_cnt++;
            last_addr  = bus_cmd_addr;
            last_burst = bus_cmd_burst;
            last_size  = bus_cmd_size;
            slv_addr   = bus_cmd_addr;
            slv_burst  = bus_cmd_burst;
            slv_size   = bus_cmd_size;
            slv_left   = bus_cmd_burst ? 2 : 1;
            slv_beat   = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // issue one read; returns data, error, latency and commands issued
    task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                           output logic [63:0] d, output logic e,
                           output int lat, output int cmds);
        int c0;
        bit ready_seen;
        @(negedge clk);
        c0 = cmd_cnt;
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        ready_seen = 1'b0;
        while (!rsp_valid && lat < 50) begin
            if (req_ready) ready_seen = 1'b1;
            @(negedge clk);
            lat++;
        end
        d = rsp_data;
        e = rsp_err;
        check(!ready_seen && !req_ready, "R11", "ready while busy", 64'(req_ready), 64'd0);
        @(negedge clk);
        check(req_ready, "R11", "ready after response", 64'(req_ready), 64'd1);
        cmds = cmd_cnt - c0;
        inj_beat = -1;
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1", "req_ready at reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid at reset", 64'(rsp_valid), 64'd0);
        check(bus_cmd_valid == 1'b0, "R1", "bus_cmd_valid at reset", 64'(bus_cmd_valid), 64'd0);
    endtask

    task automatic t_miss(input logic [31:0] a, input logic [1:0] sz, input string req);
        logic [63:0] d; logic e; int lat, cmds;
        do_read(a, sz, d, e, lat, cmds);
        check(cmds == 1, req, "miss command count", 64'(cmds), 64'd1);
        check(last_burst == 1'b1 && last_size == 2'd3, "R3", "burst flag/size",
              {61'd0, last_burst, last_size}, 64'd7);
        check(last_addr == {a[31:4], 4'h0}, "R3", "burst address", 64'(last_addr), 64'({a[31:4], 4'h0}));
        check(lat == 4, "R6", "miss latency", 64'(lat), 64'd4);
        check(!e && d == mem_bytes(a, sz), "R4", "miss data", d, mem_bytes(a, sz));
    endtask

    task automatic t_hit(input logic [31:0] a, input logic [1:0] sz, input string req);
        logic [63:0] d; logic e; int lat, cmds;
        do_read(a, sz, d, e, lat, cmds);
        check(cmds == 0, req, "hit must not touch bus", 64'(cmds), 64'd0);
        check(lat == 1, "R5", "hit latency", 64'(lat), 64'd1);
        check(!e && d == mem_bytes(a, sz), "R4", "hit data", d, mem_bytes(a, sz));
    endtask

    task automatic t_single(input logic [31:0] a, input logic [1:0] sz, input string req);
        logic [63:0] d; logic e; int lat, cmds;
        do_read(a, sz, d, e, lat, cmds);
        check(cmds == 1, req, "single command count", 64'(cmds), 64'd1);
        check(last_burst == 1'b0 && last_addr == a && last_size == sz, "R2", "single command fields",
              {29'd0, last_burst, last_size, last_addr}, {31'd0, 1'b0, sz, a});
        check(lat == 3, "R6", "single latency", 64'(lat), 64'd3);
        check(!e && d == mem_bytes(a, sz), req, "single data", d, mem_bytes(a, sz));
    endtask

    task automatic t_fill_error();
        logic [63:0] d; logic e; int lat, cmds;
        inj_beat = 1;
        do_read(32'h8000_A004, 2'd2, d, e, lat, cmds);
        check(e == 1'b1, "R9", "fill error flag", 64'(e), 64'd1);
        check(d == 64'd0, "R9", "fill error data", d, 64'd0);
        check(lat == 4, "R9", "fill error latency", 64'(lat), 64'd4);
        // line must be invalid: the same read goes to the bus again
        t_miss(32'h8000_A004, 2'd2, "R9");
    endtask

    task automatic t_single_error();
        logic [63:0] d; logic e; int lat, cmds;
        inj_beat = 0;
        do_read(32'h0000_2000, 2'd2, d, e, lat, cmds);
        check(e == 1'b1, "R10", "single error flag", 64'(e), 64'd1);
        check(lat == 3, "R10", "single error latency", 64'(lat), 64'd3);
        t_hit(32'h8000_A000, 2'd3, "R10");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        t_miss(32'h8000_1234, 2'd2, "R1");          // empty buffer
        t_hit(32'h8000_123C, 2'd2, "R5");           // upper beat
        t_hit(32'h8000_1230, 2'd3, "R5");           // lower beat
        t_hit(32'h8000_1237, 2'd1, "R4");           // across beat halves
        t_single(32'h0000_1234, 2'd1, "R2");        // outside window
        t_hit(32'h8000_1238, 2'd3, "R7");           // buffer untouched
        t_single(32'h8000_123E, 2'd2, "R8");        // spills past line end
        t_hit(32'h8000_1230, 2'd3, "R8");
        t_miss(32'h8000_5678, 2'd0, "R12");         // new line
        t_miss(32'h8000_1234, 2'd2, "R12");         // old line replaced
        t_miss(32'h8FFF_FFF0, 2'd3, "R2");          // top of window
        t_single(32'h9000_0000, 2'd2, "R2");        // just above
        t_single(32'h7FFF_FFF8, 2'd3, "R2");        // just below
        t_hit(32'h8FFF_FFF8, 2'd3, "R7");
        t_fill_error();
        t_single_error();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule